// File: doc/BRIEF.md
# Bus Controller Transaction Timer

This block sets the timing for the controller side of one message on a synchronous, redundant avionics data bus. It works in whole microseconds. Every interval is counted on a 1 MHz timebase strobe, `tick`, which is one clock wide. When a transaction is requested, the block first keeps the bus silent for the dead time required before a Select word. It then enables the transmitter one word at a time, and inserts a silent gap between consecutive words.

After the last word it keeps the line driver in its low-impedance state for a fixed hold time, and then enables the receiver. From the end of the last transmitted word it watches for the start of a reply from the addressed peripheral:

- A reply that starts before the expected reply instant is flagged as a timing error.
- If no reply has started by the timeout, a no-data status is raised.

A reply that does start keeps the receiver enabled for one reply word. The transaction then ends with a one-cycle `done` pulse. A request that arrives while a transaction is in progress is remembered. It starts as soon as the block is back in its idle state.

Top module: `bct_txn_timer`

## Requirements
- R1: While reset is asserted and directly after it, `tx_en`, `drv_hold`, `rx_en`, `busy`, `done`, `no_data` and `early_err` are all 0.
- R2: A request is accepted in the idle state and raises `busy` on the next clock. `tx_en` rises exactly DEAD_TICKS (default 8) ticks after acceptance. Ticks are counted strictly after the accepting edge.
- R3: `tx_en` stays high until `word_done` is sampled. When more words remain, all three line controls stay low for GAP_TICKS (default 3) ticks, and then `tx_en` rises for the next word. The word count `nwords` is sampled at acceptance, and a value of 0 is treated as 1.
- R4: After the last word's `word_done`, `drv_hold` is high for HOLD_TICKS (default 3) ticks, with `tx_en` and `rx_en` low. `rx_en` then rises directly as `drv_hold` falls.
- R5: If no `rx_start` is sampled while waiting, `no_data` is set and `done` pulses at the TIMEOUT_TICKS-th (default 8th) tick after the last `word_done`. `no_data` stays set until the next request is accepted, and is cleared then.
- R6: An `rx_start` sampled while waiting sets `early_err` when fewer than REPLY_TICKS (default 5) ticks have passed since the last `word_done`. It leaves `early_err` at 0 otherwise. `early_err` stays set until the next acceptance.
- R7: After an accepted `rx_start`, `rx_en` stays high for RX_TICKS (default 17) ticks. `done` then pulses for one clock with `rx_en` low, and the block returns to idle.
- R8: A request made while `busy` is high is held. It is accepted one clock after the block returns to idle, without a new request.
- R9: `word_done` is ignored outside the transmit-word phase, so it neither shortens the dead time nor consumes a word. `rx_start` is ignored outside the waiting phase, so during the hold it neither ends the wait nor sets `early_err`.
- R10: At most one of `tx_en`, `drv_hold` and `rx_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| tick | input | 1 | 1 MHz timebase strobe, one clock wide |
| start | input | 1 | Transaction request pulse |
| nwords | input | NWORD_W | Number of words to send, Select word included |
| word_done | input | 1 | Serializer reports the last bit of the current word |
| rx_start | input | 1 | Receiver reports the start of a reply word |
| tx_en | output | 1 | Transmitter enable, high while a word is sent |
| drv_hold | output | 1 | Keeps the driver at low impedance after transmission |
| rx_en | output | 1 | Receiver enable |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-clock pulse at the end of a transaction |
| no_data | output | 1 | No reply started within the timeout |
| early_err | output | 1 | A reply started before the expected instant |

## Verification
On every cycle the assertions check the following:
- At most one of the three line controls is active.
- The receiver only ever takes over directly from the driver hold.
- The dead time ends only on the right tick count.
- `no_data` rises only on the timeout tick, and `early_err` rises only after an early reply start.
- A held request is served from idle.
- The word counter never underflows.

Only the bench scenarios can show the exact span of each interval measured in ticks. They also show that a reply at 3, 4, 5, 6 or 7 ticks is classified correctly, and that the status flags stay set until the next acceptance. Finally, they show that stray `word_done` and `rx_start` pulses in the wrong phase change nothing at the ports.

// File: rtl/bct_pkg.sv
package bct_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEAD,
      ST_TX_WORD,
      ST_TX_GAP,
      ST_HOLD,
      ST_WAIT,
      ST_RX,
      ST_DONE
   } bct_state_e;

   function automatic int bct_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/bct_interval.sv
module bct_interval #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

   generate
      if (CW < 2) begin : g_bad_width
         $error("bct_interval: CW must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (tick && cnt != CNT_TOP)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/bct_word_ctr.sv
module bct_word_ctr #(
   parameter int NWORD_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NWORD_W-1:0] nwords,
   input  logic               dec,
   output logic               last
);
   logic [NWORD_W-1:0] left;

   generate
      if (NWORD_W < 1) begin : g_bad_nword
         $error("bct_word_ctr: NWORD_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         left <= '0;
      else if (load)
         left <= (nwords == '0) ? NWORD_W'(1) : nwords;
      else if (dec && left != '0)
         left <= left - 1'b1;
   end

   assign last = (left <= NWORD_W'(1));

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (left != '0)) else $error("word counter underflow"); // R3

endmodule

// File: rtl/bct_txn_timer.sv
module bct_txn_timer
   import bct_pkg::*;
#(
   parameter int DEAD_TICKS    = 8,
   parameter int GAP_TICKS     = 3,
   parameter int HOLD_TICKS    = 3,
   parameter int REPLY_TICKS   = 5,
   parameter int TIMEOUT_TICKS = 8,
   parameter int RX_TICKS      = 17,
   parameter int NWORD_W       = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               start,
   input  logic [NWORD_W-1:0] nwords,
   input  logic               word_done,
   input  logic               rx_start,
   output logic               tx_en,
   output logic               drv_hold,
   output logic               rx_en,
   output logic               busy,
   output logic               done,
   output logic               no_data,
   output logic               early_err
);
   localparam int MAX_TICKS = bct_max(bct_max(bct_max(DEAD_TICKS, GAP_TICKS),
                                              bct_max(HOLD_TICKS, REPLY_TICKS)),
                                      bct_max(TIMEOUT_TICKS, RX_TICKS));
   localparam int CW = $clog2(MAX_TICKS + 2);

   localparam logic [CW-1:0] DEAD_LAST    = CW'(DEAD_TICKS - 1);
   localparam logic [CW-1:0] GAP_LAST     = CW'(GAP_TICKS - 1);
   localparam logic [CW-1:0] HOLD_LAST    = CW'(HOLD_TICKS - 1);
   localparam logic [CW-1:0] REPLY_AT     = CW'(REPLY_TICKS);
   localparam logic [CW-1:0] TIMEOUT_LAST = CW'(TIMEOUT_TICKS - 1);
   localparam logic [CW-1:0] RX_LAST      = CW'(RX_TICKS - 1);

   generate
      if (DEAD_TICKS < 1 || GAP_TICKS < 1 || HOLD_TICKS < 1 || RX_TICKS < 1) begin : g_bad_span
         $error("bct_txn_timer: every interval needs at least one tick");
      end
      if (HOLD_TICKS > REPLY_TICKS) begin : g_bad_hold
         $error("bct_txn_timer: hold must end no later than the reply instant");
      end
      if (REPLY_TICKS >= TIMEOUT_TICKS) begin : g_bad_timeout
         $error("bct_txn_timer: timeout must come after the reply instant");
      end
   endgenerate

   bct_state_e    st, st_nx;
   logic [CW-1:0] cnt;
   logic          cnt_clr;
   logic          accept;
   logic          timeout_hit;
   logic          early_hit;
   logic          pending;
   logic          last_word;

   always_comb begin
      st_nx       = st;
      accept      = 1'b0;
      timeout_hit = 1'b0;
      early_hit   = 1'b0;
      case (st)
         ST_IDLE:    if (start || pending) begin
                        st_nx  = ST_DEAD;
                        accept = 1'b1;
                     end
         ST_DEAD:    if (tick && cnt == DEAD_LAST) st_nx = ST_TX_WORD;
         ST_TX_WORD: if (word_done) st_nx = last_word ? ST_HOLD : ST_TX_GAP;
         ST_TX_GAP:  if (tick && cnt == GAP_LAST) st_nx = ST_TX_WORD;
         ST_HOLD:    if (tick && cnt == HOLD_LAST) st_nx = ST_WAIT;
         ST_WAIT:    if (rx_start) begin
                        st_nx     = ST_RX;
                        early_hit = (cnt < REPLY_AT);
                     end else if (tick && cnt == TIMEOUT_LAST) begin
                        st_nx       = ST_DONE;
                        timeout_hit = 1'b1;
                     end
         ST_RX:      if (tick && cnt == RX_LAST) st_nx = ST_DONE;
         ST_DONE:    st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   // the hold and the wait share one elapsed count from the last word
   assign cnt_clr = (st_nx != st) && (st != ST_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         pending   <= 1'b0;
         no_data   <= 1'b0;
         early_err <= 1'b0;
      end else begin
         st <= st_nx;
         if (accept)
            pending <= 1'b0;
         else if (start && st != ST_IDLE)
            pending <= 1'b1;
         if (accept)
            no_data <= 1'b0;
         else if (timeout_hit)
            no_data <= 1'b1;
         if (accept)
            early_err <= 1'b0;
         else if (early_hit)
            early_err <= 1'b1;
      end
   end

   bct_interval #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .tick  (tick),
      .cnt   (cnt)
   );

   bct_word_ctr #(.NWORD_W(NWORD_W)) u_words (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .nwords (nwords),
      .dec    (st == ST_TX_WORD && word_done),
      .last   (last_word)
   );

   assign tx_en    = (st == ST_TX_WORD);
   assign drv_hold = (st == ST_HOLD);
   assign rx_en    = (st == ST_WAIT) || (st == ST_RX);
   assign busy     = (st != ST_IDLE);
   assign done     = (st == ST_DONE);

   AST_DEAD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX_WORD && $past(st) == ST_DEAD) |-> ($past(tick) && $past(cnt) == DEAD_LAST))
      else $error("dead time ended off count"); // R2
   AST_HOLD_TO_RX: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_hold) |-> rx_en) else $error("hold not followed by receive"); // R4
   AST_RX_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_en) |-> $past(drv_hold)) else $error("receive without hold"); // R4
   AST_NODATA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(no_data) |-> ($past(tick) && $past(cnt) == TIMEOUT_LAST))
      else $error("no-data off timeout"); // R5
   AST_EARLY_ONLY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(early_err) |-> ($past(rx_start) && $past(cnt) < REPLY_AT))
      else $error("early flag without early reply"); // R6
   AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && st == ST_IDLE) |=> (st == ST_DEAD)) else $error("held request lost"); // R8
   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_en, drv_hold, rx_en})) else $error("line controls overlap"); // R10

endmodule

// File: tb/bct_txn_timer_test.sv
module bct_txn_timer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick;
   logic       start = 1'b0;
   logic [4:0] nwords = 5'd1;
   logic       word_done = 1'b0;
   logic       rx_start = 1'b0;
   logic       tx_en, drv_hold, rx_en, busy, done, no_data, early_err;

   int checks = 0;
   int failures = 0;
   int overlap = 0;
   int tick_cnt = 0;
   int div = 0;

   always #4 clk = ~clk;

   always @(posedge clk) div <= (div == 4) ? 0 : div + 1;
   assign tick = (div == 0);
   always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

   bct_txn_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .nwords(nwords),
      .word_done(word_done), .rx_start(rx_start), .tx_en(tx_en), .drv_hold(drv_hold),
      .rx_en(rx_en), .busy(busy), .done(done), .no_data(no_data), .early_err(early_err)
   );

   always @(negedge clk)
      if (rst_n && (int'(tx_en) + int'(drv_hold) + int'(rx_en)) > 1) overlap++;

   // nwords, reply tick (0 = none), expected early_err, expected no_data
   localparam int NVEC = 6;
   localparam int VEC [0:NVEC-1][0:3] = '{
      '{1, 0, 0, 1},
      '{2, 5, 0, 0},
      '{3, 4, 1, 0},
      '{1, 7, 0, 0},
      '{2, 3, 1, 0},
      '{1, 6, 0, 0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic wait_tx();
      do @(negedge clk); while (!tx_en);
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   task automatic pulse_start(input int nw);
      @(negedge clk);
      start = 1'b1;
      nwords = 5'(nw);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic send_word(output int g0);
      repeat (6) @(negedge clk);
      word_done = 1'b1;
      @(negedge clk);
      word_done = 1'b0;
      g0 = tick_cnt;
   endtask

   task automatic run_txn(input int nw, input int k, input int exp_early, input int exp_nd);
      int t0, g0, r0;
      pulse_start(nw);
      t0 = tick_cnt;
      chk(busy == 1'b1, "R2 busy after accept", busy, 1);
      chk(no_data == 1'b0 && early_err == 1'b0, "R5 flags cleared on accept", no_data, 0);
      wait_tx();
      chk(tick_cnt - t0 == 8, "R2 dead ticks", tick_cnt - t0, 8);
      for (int w = 0; w < nw; w++) begin
         if (w > 0) begin
            wait_tx();
            chk(tick_cnt - g0 == 3, "R3 gap ticks", tick_cnt - g0, 3);
         end
         send_word(g0);
         chk(tx_en == 1'b0, "R3 tx_en drops on word_done", tx_en, 0);
         if (w < nw - 1)
            chk(drv_hold == 1'b0 && rx_en == 1'b0, "R3 silent gap", drv_hold, 0);
         else
            chk(drv_hold == 1'b1 && rx_en == 1'b0, "R4 hold after last word", drv_hold, 1);
      end
      do @(negedge clk); while (!rx_en);
      chk(tick_cnt - g0 == 3, "R4 hold ticks", tick_cnt - g0, 3);
      if (k == 0) begin
         wait_done();
         chk(tick_cnt - g0 == 8, "R5 timeout ticks", tick_cnt - g0, 8);
         chk(no_data == exp_nd, "R5 no_data", no_data, exp_nd);
      end else begin
         while (tick_cnt - g0 < k) @(negedge clk);
         rx_start = 1'b1;
         @(negedge clk);
         rx_start = 1'b0;
         r0 = tick_cnt;
         chk(early_err == exp_early, "R6 early_err", early_err, exp_early);
         chk(rx_en == 1'b1, "R7 rx_en during reply", rx_en, 1);
         wait_done();
         chk(tick_cnt - r0 == 17, "R7 reply ticks", tick_cnt - r0, 17);
         chk(rx_en == 1'b0, "R7 rx_en low at done", rx_en, 0);
         chk(no_data == exp_nd, "R5 no_data after reply", no_data, exp_nd);
      end
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R7 back to idle", busy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int t0, g0;
      repeat (3) @(negedge clk);
      chk({tx_en, drv_hold, rx_en, busy, done, no_data, early_err} == 7'd0,
          "R1 outputs during reset", int'({tx_en, drv_hold, rx_en, busy}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({tx_en, drv_hold, rx_en, busy, done, no_data, early_err} == 7'd0,
          "R1 outputs after reset", int'({tx_en, drv_hold, rx_en, busy}), 0);

      for (int v = 0; v < NVEC; v++)
         run_txn(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

      // R5: no_data stays set in idle until the next acceptance
      run_txn(1, 0, 0, 1);
      repeat (10) @(negedge clk);
      chk(no_data == 1'b1, "R5 no_data held in idle", no_data, 1);
      run_txn(1, 6, 0, 0);

      // R9: stray word_done in dead time, stray rx_start during hold
      pulse_start(2);
      t0 = tick_cnt;
      repeat (3) @(negedge clk);
      word_done = 1'b1;
      @(negedge clk);
      word_done = 1'b0;
      chk(tx_en == 1'b0, "R9 word_done ignored in dead time", tx_en, 0);
      wait_tx();
      chk(tick_cnt - t0 == 8, "R9 dead time unchanged", tick_cnt - t0, 8);
      send_word(g0);
      chk(drv_hold == 1'b0, "R9 word not consumed early", drv_hold, 0);
      wait_tx();
      send_word(g0);
      chk(drv_hold == 1'b1, "R9 hold after second word", drv_hold, 1);
      rx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0;
      chk(drv_hold == 1'b1 && early_err == 1'b0, "R9 rx_start ignored in hold", early_err, 0);
      wait_done();
      chk(tick_cnt - g0 == 8 && no_data == 1'b1, "R9 timeout still reached", tick_cnt - g0, 8);
      @(negedge clk);

      // R8: request during a busy transaction is held
      pulse_start(1);
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_tx();
      send_word(g0);
      wait_done();
      @(negedge clk);
      chk(busy == 1'b0, "R8 idle for one clock", busy, 0);
      @(negedge clk);
      t0 = tick_cnt;
      chk(busy == 1'b1, "R8 held request accepted", busy, 1);
      wait_tx();
      chk(tick_cnt - t0 == 8, "R8 held request dead time", tick_cnt - t0, 8);
      send_word(g0);
      wait_done();
      @(negedge clk);
      chk(busy == 1'b0, "R8 no further request", busy, 0);

      // R1: reset in the middle of a transaction
      pulse_start(1);
      wait_tx();
      rst_n = 1'b0;
      @(negedge clk);
      chk({tx_en, drv_hold, rx_en, busy, done} == 5'd0, "R1 mid-run reset", tx_en, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R1 idle after reset", busy, 0);

      chk(overlap == 0, "R10 line controls exclusive", overlap, 0);
      summary();
   end

endmodule